// File: doc/BRIEF.md
# Oscillator Start-up and Clock Handover Controller

This block moves the system clock from a secondary internal oscillator back to a primary oscillator once software clears a clock-select bit. It runs on a fast sampling clock. The two oscillators arrive as sampled levels that are synchronous to that clock, and the block makes the edges of the system clock from them. Alongside the system clock it drives a four-phase instruction-cycle indicator, a completion flag that software can poll, and an enable that lets the internal oscillator be shut down once nothing needs it.

The primary mode decides how the switch runs. A crystal-type primary has to prove itself first: a start-up timer must count a fixed number of primary rising edges, and the internal clock keeps running the system meanwhile. A non-crystal primary (external clock or RC) skips that count. Instead, once the handover is made, a short stabilisation stall follows, measured in internal-oscillator cycles. In both modes the controller waits for the phase indicator to wrap to Q1. It then parks the system clock low, and picks up the primary clock only at a primary falling edge, so the system clock never carries a runt pulse.

Top module: `osc_handover`

## Requirements
- R1: Reset is synchronous and active high. While it is held, and before any later system-clock rising edge, the outputs are: `sys_clk_o` 0, `phase_o` 0 (Q1), `switch_done_o` 0 and `int_osc_en_o` 1. After reset the system clock follows the internal oscillator.
- R2: When `pri_xtal_i` is 1 (crystal-type primary), a 1-to-0 transition of `sel_int_i` starts a start-up count of `OST_CYC` primary rising edges. During this count `sys_clk_o` keeps following the internal oscillator, so completion takes at least `OST_CYC` primary periods.
- R3: When `pri_xtal_i` is 0 (non-crystal primary), the start-up count is skipped, and completion comes well within `OST_CYC` primary periods.
- R4: After the start-up step, the controller waits for the system-clock rising edge that moves the phase from Q4 to Q1. It then holds `sys_clk_o` low from the next internal falling edge onwards. At the first primary falling edge after that, `sys_clk_o` begins to follow the primary oscillator.
- R5: With a non-crystal primary, `sys_clk_o` stays low and the phase stays at Q1 after the release for `STAB_CYC` internal rising edges. It then follows the primary from a cycle in which the primary is low.
- R6: `phase_o` encodes Q1=0, Q2=1, Q3=2 and Q4=3. It steps by one, wrapping from 3 to 0, on each rising edge of `sys_clk_o`, and it never changes at any other time.
- R7: Setting `sel_int_i` back to 1 before completion abandons the switch and returns to the internal clock. The next request must then count the full start-up span again.
- R8: `switch_done_o` is 1 only while the primary drives the system clock. It is set when the handover completes and cleared when a new request starts or when the clock returns to internal.
- R9: `int_osc_en_o` is 0 only when the switch has completed and both `wdt_need_i` and `fscm_need_i` are 0.
- R10: While running on the primary, setting `sel_int_i` to 1 returns the system clock to the internal oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| int_osc_i | input | 1 | Sampled internal oscillator level |
| pri_osc_i | input | 1 | Sampled primary oscillator level |
| pri_xtal_i | input | 1 | 1: crystal-type primary, 0: external clock or RC |
| sel_int_i | input | 1 | Clock-select bit, 1 selects internal |
| wdt_need_i | input | 1 | Watchdog still needs the internal oscillator |
| fscm_need_i | input | 1 | Fail-safe monitor still needs the internal oscillator |
| sys_clk_o | output | 1 | Gated system clock |
| phase_o | output | 2 | Instruction phase, Q1=0 to Q4=3 |
| switch_done_o | output | 1 | Handover to primary complete |
| int_osc_en_o | output | 1 | Internal oscillator enable |

## Verification
The bench runs the handover in crystal mode and in non-crystal mode, at two primary periods, so the wrap to Q1 and the primary falling edge fall at different offsets from each other. It abandons a crystal switch midway and then times the retry. A design that kept the counter from the first attempt would finish too early on the retry. It also leaves the primary, and toggles the two need flags. A design that released the park on the wrong primary edge, or let the phase step while parked, would fail the cycle-by-cycle comparison on `sys_clk_o` or `phase_o`. A design that skipped the stall for a non-crystal primary would finish faster than the stall allows.

// File: rtl/osc_handover_pkg.sv
package osc_handover_pkg;

    typedef enum logic [2:0] {
        ST_INT   = 3'd0,
        ST_OST   = 3'd1,
        ST_SYNC  = 3'd2,
        ST_PARK  = 3'd3,
        ST_STALL = 3'd4,
        ST_PRI   = 3'd5
    } hs_state_e;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic phase_e next_phase(input phase_e p);
        return phase_e'(p + 2'd1);
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hs_edge_det.sv
module hs_edge_det
    import osc_handover_pkg::*;
#(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_i,
    output edge_t        edge_o [N]
);
    logic [N-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= lvl_i;
    end

    for (genvar g = 0; g < N; g++) begin : g_edge
        assign edge_o[g].rise = lvl_i[g] & ~lvl_q[g];
        assign edge_o[g].fall = ~lvl_i[g] & lvl_q[g];
    end
endmodule

// File: rtl/hs_cycle_timer.sv
module hs_cycle_timer #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i)               cnt_o <= '0;
        else if (inc_i && cnt_o != '1)  cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/hs_phase_seq.sv
module hs_phase_seq
    import osc_handover_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv_i,
    output phase_e phase_o
);
    always_ff @(posedge clk) begin
        if (rst)        phase_o <= PH_Q1;
        else if (adv_i) phase_o <= next_phase(phase_o);
    end

    assert_phase_step_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_o != $past(phase_o)) |-> (phase_o == next_phase($past(phase_o))));
endmodule

// File: rtl/osc_handover.sv
module osc_handover
    import osc_handover_pkg::*;
#(
    parameter int OST_CYC  = 1024,
    parameter int STAB_CYC = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       int_osc_i,
    input  logic       pri_osc_i,
    input  logic       pri_xtal_i,
    input  logic       sel_int_i,
    input  logic       wdt_need_i,
    input  logic       fscm_need_i,
    output logic       sys_clk_o,
    output logic [1:0] phase_o,
    output logic       switch_done_o,
    output logic       int_osc_en_o
);
    localparam int CW = $clog2(max_int(OST_CYC, STAB_CYC) + 1);
    localparam logic [CW-1:0] OST_LAST = CW'(OST_CYC - 1);
    localparam logic [CW-1:0] STAB_END = CW'(STAB_CYC);

    hs_state_e state_q, state_d;
    logic      done_d, parked_q, parked_d, sys_d, sys_rise;
    logic      cnt_clr, cnt_inc;
    logic [CW-1:0] cnt;
    phase_e    phase;
    edge_t     edges [3];

    hs_edge_det #(.N(3)) u_edges (
        .clk   (clk),
        .rst   (rst),
        .lvl_i ({sel_int_i, pri_osc_i, int_osc_i}),
        .edge_o(edges)
    );

    hs_cycle_timer #(.W(CW)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clr_i(cnt_clr),
        .inc_i(cnt_inc),
        .cnt_o(cnt)
    );

    hs_phase_seq u_phase (
        .clk    (clk),
        .rst    (rst),
        .adv_i  (sys_rise),
        .phase_o(phase)
    );

    always_comb begin
        unique case (state_q)
            ST_PARK:  sys_d = int_osc_i & ~parked_q;
            ST_STALL: sys_d = 1'b0;
            ST_PRI:   sys_d = pri_osc_i;
            default:  sys_d = int_osc_i;
        endcase
        sys_rise = sys_d & ~sys_clk_o;
    end

    always_comb begin
        state_d  = state_q;
        done_d   = switch_done_o;
        parked_d = parked_q;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        unique case (state_q)
            ST_INT: begin
                if (edges[2].fall) begin
                    cnt_clr = 1'b1;
                    done_d  = 1'b0;
                    state_d = pri_xtal_i ? ST_OST : ST_SYNC;
                end
            end
            ST_OST: begin
                if (sel_int_i) begin
                    state_d = ST_INT;
                    cnt_clr = 1'b1;
                end else if (edges[1].rise) begin
                    if (cnt == OST_LAST) begin
                        state_d = ST_SYNC;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_SYNC: begin
                if (sel_int_i) state_d = ST_INT;
                else if (sys_rise && phase == PH_Q4) begin
                    state_d  = ST_PARK;
                    parked_d = 1'b0;
                end
            end
            ST_PARK: begin
                if (sel_int_i) begin
                    state_d  = ST_INT;
                    parked_d = 1'b0;
                end else begin
                    if (!int_osc_i) parked_d = 1'b1;
                    if (parked_q && edges[1].fall) begin
                        parked_d = 1'b0;
                        cnt_clr  = 1'b1;
                        if (pri_xtal_i) begin
                            state_d = ST_PRI;
                            done_d  = 1'b1;
                        end else begin
                            state_d = ST_STALL;
                        end
                    end
                end
            end
            ST_STALL: begin
                if (sel_int_i) begin
                    state_d = ST_INT;
                    cnt_clr = 1'b1;
                end else if (cnt == STAB_END) begin
                    if (!pri_osc_i) begin
                        state_d = ST_PRI;
                        done_d  = 1'b1;
                    end
                end else if (edges[0].rise) begin
                    cnt_inc = 1'b1;
                end
            end
            ST_PRI: begin
                if (sel_int_i) begin
                    state_d = ST_INT;
                    done_d  = 1'b0;
                end
            end
            default: state_d = ST_INT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_INT;
            switch_done_o <= 1'b0;
            parked_q      <= 1'b0;
            sys_clk_o     <= 1'b0;
        end else begin
            state_q       <= state_d;
            switch_done_o <= done_d;
            parked_q      <= parked_d;
            sys_clk_o     <= sys_d;
        end
    end

    assign phase_o      = phase;
    assign int_osc_en_o = !(state_q == ST_PRI && !wdt_need_i && !fscm_need_i);

    assert_ost_span_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OST) |-> (cnt < CW'(OST_CYC)));
    assert_park_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PARK && parked_q) |=> $stable(phase_o));
    assert_stall_low_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STALL) |-> !sys_clk_o);
    assert_done_on_pri_R8: assert property (@(posedge clk) disable iff (rst)
        switch_done_o |-> (state_q == ST_PRI));
endmodule

// File: tb/tb_osc_handover.sv
module tb_osc_handover;
    localparam int OST  = 20;
    localparam int STAB = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic int_osc = 1'b0, pri_osc = 1'b0, xtal = 1'b1, sel = 1'b1;
    logic wdt = 1'b0, fscm = 1'b0;
    logic sys_clk, done, int_en;
    logic [1:0] phase;

    int checks = 0, errors = 0, cyc = 0;
    int pri_half = 3, int_cnt = 0, pri_cnt = 0;

    always #2 clk = ~clk;

    osc_handover #(.OST_CYC(OST), .STAB_CYC(STAB)) dut (
        .clk(clk), .rst(rst), .int_osc_i(int_osc), .pri_osc_i(pri_osc),
        .pri_xtal_i(xtal), .sel_int_i(sel), .wdt_need_i(wdt), .fscm_need_i(fscm),
        .sys_clk_o(sys_clk), .phase_o(phase), .switch_done_o(done), .int_osc_en_o(int_en)
    );

    // oscillator sources, driven away from the active edge
    always @(negedge clk) begin
        int_cnt++;
        if (int_cnt >= 2) begin int_cnt = 0; int_osc <= ~int_osc; end
        pri_cnt++;
        if (pri_cnt >= pri_half) begin pri_cnt = 0; pri_osc <= ~pri_osc; end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference: mode 0 internal, 1 counting, 2 wait for Q1,
    // 3 parked, 4 stall, 5 primary
    int  m_mode = 0, m_cnt = 0, m_ph = 0;
    bit  m_park = 0, m_sys = 0, m_done = 0;
    bit  o_int = 0, o_pri = 0, o_sel = 0;

    always @(posedge clk) begin
        bit nsys, up, irise, prise, pfall, sfall;
        int nmode;
        if (rst) begin
            m_mode = 0; m_cnt = 0; m_ph = 0; m_park = 0; m_sys = 0; m_done = 0;
            o_int = 0; o_pri = 0; o_sel = 0;
        end else begin
            irise = int_osc && !o_int;
            prise = pri_osc && !o_pri;
            pfall = !pri_osc && o_pri;
            sfall = !sel && o_sel;
            if (m_mode == 5)      nsys = pri_osc;
            else if (m_mode == 4) nsys = 0;
            else if (m_mode == 3) nsys = int_osc && !m_park;
            else                  nsys = int_osc;
            up = nsys && !m_sys;
            nmode = m_mode;
            if (m_mode != 0 && sel) begin
                nmode = 0; m_cnt = 0; m_park = 0; m_done = 0;
            end else if (m_mode == 0 && sfall) begin
                m_cnt = 0; m_done = 0;
                nmode = xtal ? 1 : 2;
            end else if (m_mode == 1 && prise) begin
                m_cnt++;
                if (m_cnt == OST) begin nmode = 2; m_cnt = 0; end
            end else if (m_mode == 2 && up && m_ph == 3) begin
                nmode = 3; m_park = 0;
            end else if (m_mode == 3) begin
                if (m_park && pfall) begin
                    m_park = 0; m_cnt = 0;
                    if (xtal) begin nmode = 5; m_done = 1; end
                    else nmode = 4;
                end else if (!int_osc) m_park = 1;
            end else if (m_mode == 4) begin
                if (m_cnt >= STAB) begin
                    if (!pri_osc) begin nmode = 5; m_done = 1; end
                end else if (irise) m_cnt++;
            end
            if (up) m_ph = (m_ph + 1) % 4;
            m_sys = nsys;
            m_mode = nmode;
            o_int = int_osc; o_pri = pri_osc; o_sel = sel;
        end
    end

    always @(negedge clk) begin
        bit exp_en;
        cyc++;
        exp_en = !(m_mode == 5 && !wdt && !fscm);
        check(sys_clk == m_sys, "R4 sys_clk", sys_clk, m_sys);
        check(phase == m_ph,    "R6 phase",   phase,   m_ph);
        check(done == m_done,   "R8 done",    done,    m_done);
        check(int_en == exp_en, "R9 int_en",  int_en,  exp_en);
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        check(sys_clk == 0 && phase == 0 && done == 0 && int_en == 1, "R1 reset", {sys_clk, phase, done, int_en}, 1);
        rst = 1'b0;
        repeat (40) @(negedge clk);

        // crystal switch
        sel = 1'b0;
        wait_done(n);
        check(done == 1, "R2 done", done, 1);
        check(n >= OST * 2 * pri_half, "R2 span", n, OST * 2 * pri_half);
        repeat (3) @(negedge clk);
        check(int_en == 0, "R9 off", int_en, 0);
        wdt = 1'b1; #1;
        check(int_en == 1, "R9 wdt", int_en, 1);
        wdt = 1'b0; fscm = 1'b1; #1;
        check(int_en == 1, "R9 fscm", int_en, 1);
        fscm = 1'b0;
        repeat (30) @(negedge clk);

        // back to internal
        sel = 1'b1;
        repeat (2) @(negedge clk);
        check(done == 0, "R10 leave", done, 0);
        check(int_en == 1, "R10 int_en", int_en, 1);
        repeat (30) @(negedge clk);

        // non-crystal switch, other primary period
        pri_half = 5;
        xtal = 1'b0;
        sel = 1'b0;
        wait_done(n);
        check(done == 1, "R3 done", done, 1);
        check(n < OST * 2 * pri_half, "R3 no count", n, OST * 2 * pri_half);
        check(n >= STAB * 4, "R5 stall", n, STAB * 4);
        repeat (40) @(negedge clk);
        sel = 1'b1;
        repeat (30) @(negedge clk);

        // abandon a crystal switch midway, then retry
        xtal = 1'b1;
        sel = 1'b0;
        repeat (OST * pri_half) @(negedge clk);
        sel = 1'b1;
        repeat (20) @(negedge clk);
        check(done == 0, "R7 abandon", done, 0);
        sel = 1'b0;
        wait_done(n);
        check(done == 1, "R7 retry done", done, 1);
        check(n >= OST * 2 * pri_half, "R7 full recount", n, OST * 2 * pri_half);
        repeat (20) @(negedge clk);

        // abandon during a non-crystal handover
        sel = 1'b1;
        repeat (20) @(negedge clk);
        xtal = 1'b0;
        sel = 1'b0;
        repeat (12) @(negedge clk);
        sel = 1'b1;
        repeat (30) @(negedge clk);
        check(done == 0, "R7 abandon ec", done, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule